// File: doc/BRIEF.md
# Circular Message Queue Pointer Controller

This block keeps the head and tail pointers of four circular message queues that live in shared memory. A single base register and a single size field place the four queue regions back to back from a 1 MiB aligned base, in a fixed order. The order is inbound free, then inbound post, then outbound post, then outbound free. Each region spans the size field times 16 KiB.

Software programs the control and base registers and can rewrite any pointer at any time. Two hardware strobes move pointers on their own. A host post advances the inbound post head. A host read of the outbound port advances the outbound post tail. The block reports these per queue:

- an empty flag;
- an overflow flag, set when a post had to be refused because the queue was full;
- an interrupt request while posted messages are pending.

It also presents the addresses the host should use for its next post and its next read. It moves no data itself.

Top module: `msgq_ptr_ctrl`

## Requirements
- R1: After reset, every register reads zero, all four empty flags are 1, all overflow flags are 0 and post_irq is 0.
- R2: Register addresses are: 0 is control, with bit 0 the enable and bits 5:1 the size; 1 is the base, which keeps only bits 31:20 and reads the rest as zero; 2+2q is the head of queue q and 3+2q is its tail. The queue indices are q=0 inbound free, 1 inbound post, 2 outbound post, 3 outbound free. Written values read back on the cycle after the write.
- R3: Queue q starts at (base & 0xFFF00000) + q × size × 16384.
- R4: A control write with bit 0 set loads every head and tail with its queue's start address, computed from the newly written size, and clears all overflow flags. The result is visible on the next cycle.
- R5: While enabled, a host_post cycle advances the inbound post head by 4. host_post_addr always shows that head.
- R6: An advance that reaches the end of a queue's region wraps the pointer to the region start.
- R7: A host_post whose advance would make the inbound post head equal its tail leaves the head unchanged and sets q_ovf[1].
- R8: While enabled, a host_read cycle advances the outbound post tail by 4 if that queue is not empty. On an empty queue the tail stays put. host_read_addr always shows that tail.
- R9: q_empty[q] is 1 exactly when head q equals tail q.
- R10: post_irq is 1 exactly while the inbound post queue is not empty.
- R11: While the enable bit is 0, host_post and host_read move no pointer, and software pointer writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_addr | input | 4 | Software write register address |
| sw_wdata | input | 32 | Software write data |
| sw_rd_addr | input | 4 | Software read register address |
| sw_rdata | output | 32 | Read data for sw_rd_addr (combinational) |
| host_post | input | 1 | Host posted a message to the inbound port |
| host_read | input | 1 | Host read a message from the outbound port |
| host_post_addr | output | 32 | Inbound post head: the next post slot |
| host_read_addr | output | 32 | Outbound post tail: the next read slot |
| q_empty | output | 4 | Per-queue empty flags |
| q_ovf | output | 4 | Per-queue refused-push flags |
| post_irq | output | 1 | Inbound post queue has pending entries |

## Verification
A corrupted head or tail surfaces on the cycle after the faulty update, in three places: the readback of that pointer, host_post_addr or host_read_addr, and q_empty and post_irq. A bad start address or wrap bound stays hidden until an enabling write or a pointer reaches the end of its region. The bench therefore forces both events with pointers placed one slot before the boundary. A missing overflow refusal shows as the head landing on the tail: the queue then reads empty and post_irq drops while messages are still pending.

// File: rtl/msgq_pkg.sv
// Shared constants for the message queue pointer controller.
// Assumes four queues in a fixed memory order; register indices are fixed.
package msgq_pkg;
    localparam int NQ = 4;
    typedef enum logic [1:0] {
        Q_IN_FREE  = 2'd0,
        Q_IN_POST  = 2'd1,
        Q_OUT_POST = 2'd2,
        Q_OUT_FREE = 2'd3
    } q_id_e;
    localparam int REG_CTRL = 0;
    localparam int REG_BASE = 1;
    localparam int REG_PTR0 = 2;
endpackage

// File: rtl/msgq_region_calc.sv
// Computes the start address of each queue region and the region length.
// Assumes the base is already aligned by the caller's mask; purely combinational.
module msgq_region_calc #(
    parameter int AW         = 32,
    parameter int SZW        = 5,
    parameter int UNIT_SHIFT = 14,
    parameter int NQ         = 4
) (
    input  logic [AW-1:0]          base_i,
    input  logic [SZW-1:0]         size_i,
    output logic [NQ-1:0][AW-1:0]  start_o,
    output logic [AW-1:0]          len_o
);
    // region length and per-queue offsets from the shared base
    always_comb begin
        len_o = AW'(size_i) << UNIT_SHIFT;
        for (int q = 0; q < NQ; q++) begin
            start_o[q] = base_i + AW'(q) * len_o;
        end
    end
endmodule

// File: rtl/msgq_ptr_pair.sv
// Holds head and tail for one circular queue. Push advances the head and pop
// advances the tail, each by STEP bytes with wrap to the region start.
// Assumes at most one of init / software write / auto move wins per pointer
// (init first, then software). A push that would meet the tail is refused.
module msgq_ptr_pair #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_i,
    input  logic [AW-1:0] len_i,
    input  logic          init_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          sw_head_we_i,
    input  logic          sw_tail_we_i,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] head_o,
    output logic [AW-1:0] tail_o,
    output logic          empty_o,
    output logic          ovf_o
);
    logic [AW-1:0] head_q, tail_q, head_nxt, tail_nxt;
    logic          full_hit;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p,
                                              input logic [AW-1:0] s,
                                              input logic [AW-1:0] l);
        logic [AW-1:0] n;
        n = p + AW'(STEP);
        if (n >= s + l) n = s;
        return n;
    endfunction

    // next positions and full detection
    always_comb begin
        head_nxt = advance(head_q, start_i, len_i);
        tail_nxt = advance(tail_q, start_i, len_i);
        full_hit = (head_nxt == tail_q);
    end

    // head register: init, software write, then refused-if-full push
    always_ff @(posedge clk) begin
        if (!rst_n)                     head_q <= '0;
        else if (init_i)                head_q <= start_i;
        else if (sw_head_we_i)          head_q <= wdata_i;
        else if (push_i && !full_hit)   head_q <= head_nxt;
    end

    // tail register: init, software write, then pop when not empty
    always_ff @(posedge clk) begin
        if (!rst_n)                     tail_q <= '0;
        else if (init_i)                tail_q <= start_i;
        else if (sw_tail_we_i)          tail_q <= wdata_i;
        else if (pop_i && !empty_o)     tail_q <= tail_nxt;
    end

    // overflow flag: set on a refused push, cleared by init
    always_ff @(posedge clk) begin
        if (!rst_n)                                      ovf_o <= 1'b0;
        else if (init_i)                                 ovf_o <= 1'b0;
        else if (push_i && !sw_head_we_i && full_hit)    ovf_o <= 1'b1;
    end

    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign empty_o = (head_q == tail_q);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !sw_head_we_i && !init_i) |=> $stable(head_o));
    // R8
    tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_i && !sw_tail_we_i && !init_i) |=> $stable(tail_o));
    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !sw_tail_we_i && !init_i) |=> $stable(tail_o));
    // R7
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(push_i));
endmodule

// File: rtl/msgq_ptr_ctrl.sv
// Top of the message queue pointer controller: control/base registers,
// register decode and readback, region computation and four pointer pairs.
// Assumes one software write and one read address per cycle; read is combinational.
module msgq_ptr_ctrl #(
    parameter int AW         = 32,
    parameter int RAW        = 4,
    parameter int SZW        = 5,
    parameter int UNIT_SHIFT = 14,
    parameter int BASE_LSB   = 20,
    parameter int STEP       = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_wr_en,
    input  logic [RAW-1:0] sw_addr,
    input  logic [AW-1:0]  sw_wdata,
    input  logic [RAW-1:0] sw_rd_addr,
    output logic [AW-1:0]  sw_rdata,
    input  logic           host_post,
    input  logic           host_read,
    output logic [AW-1:0]  host_post_addr,
    output logic [AW-1:0]  host_read_addr,
    output logic [3:0]     q_empty,
    output logic [3:0]     q_ovf,
    output logic           post_irq
);
    import msgq_pkg::*;

    localparam int BHW = AW - BASE_LSB;

    logic                 ctrl_en;
    logic [SZW-1:0]       ctrl_size;
    logic [BHW-1:0]       base_hi;
    logic                 wr_ctrl, wr_base, init_p;
    logic [SZW-1:0]       size_sel;
    logic [NQ-1:0][AW-1:0] q_start;
    logic [AW-1:0]        q_len;
    logic [NQ-1:0][AW-1:0] head, tail;

    // decode of control and base writes
    always_comb begin
        wr_ctrl  = sw_wr_en && (sw_addr == RAW'(REG_CTRL));
        wr_base  = sw_wr_en && (sw_addr == RAW'(REG_BASE));
        init_p   = wr_ctrl && sw_wdata[0];
        size_sel = wr_ctrl ? sw_wdata[SZW:1] : ctrl_size;
    end

    // control register: enable bit and size field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_size <= '0;
        end else if (wr_ctrl) begin
            ctrl_en   <= sw_wdata[0];
            ctrl_size <= sw_wdata[SZW:1];
        end
    end

    // base register keeps only the aligned upper bits
    always_ff @(posedge clk) begin
        if (!rst_n)       base_hi <= '0;
        else if (wr_base) base_hi <= sw_wdata[AW-1:BASE_LSB];
    end

    msgq_region_calc #(.AW(AW), .SZW(SZW), .UNIT_SHIFT(UNIT_SHIFT), .NQ(NQ)) u_region (
        .base_i  ({base_hi, {BASE_LSB{1'b0}}}),
        .size_i  (size_sel),
        .start_o (q_start),
        .len_o   (q_len)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic hwe, twe, push, pop;
        // per-queue write decode and hardware strobe routing
        always_comb begin
            hwe  = sw_wr_en && (sw_addr == RAW'(REG_PTR0 + 2*q));
            twe  = sw_wr_en && (sw_addr == RAW'(REG_PTR0 + 2*q + 1));
            push = (q == int'(Q_IN_POST))  ? (host_post && ctrl_en) : 1'b0;
            pop  = (q == int'(Q_OUT_POST)) ? (host_read && ctrl_en) : 1'b0;
        end
        msgq_ptr_pair #(.AW(AW), .STEP(STEP)) u_pair (
            .clk          (clk),
            .rst_n        (rst_n),
            .start_i      (q_start[q]),
            .len_i        (q_len),
            .init_i       (init_p),
            .wdata_i      (sw_wdata),
            .sw_head_we_i (hwe),
            .sw_tail_we_i (twe),
            .push_i       (push),
            .pop_i        (pop),
            .head_o       (head[q]),
            .tail_o       (tail[q]),
            .empty_o      (q_empty[q]),
            .ovf_o        (q_ovf[q])
        );
    end

    // register readback mux
    always_comb begin
        sw_rdata = '0;
        if (sw_rd_addr == RAW'(REG_CTRL))
            sw_rdata = AW'({ctrl_size, ctrl_en});
        else if (sw_rd_addr == RAW'(REG_BASE))
            sw_rdata = {base_hi, {BASE_LSB{1'b0}}};
        else
            for (int q = 0; q < NQ; q++) begin
                if (sw_rd_addr == RAW'(REG_PTR0 + 2*q))     sw_rdata = head[q];
                if (sw_rd_addr == RAW'(REG_PTR0 + 2*q + 1)) sw_rdata = tail[q];
            end
    end

    assign host_post_addr = head[Q_IN_POST];
    assign host_read_addr = tail[Q_OUT_POST];
    assign post_irq       = !q_empty[Q_IN_POST];

    // R4
    init_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_p |=> (q_ovf == 4'b0000));
    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !sw_wr_en) |=> ($stable(host_post_addr) && $stable(host_read_addr)));
endmodule

// File: tb/msgq_ptr_ctrl_tb.sv
module msgq_ptr_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [3:0]  sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [3:0]  sw_rd_addr = '0;
    logic [31:0] sw_rdata;
    logic        host_post = 1'b0;
    logic        host_read = 1'b0;
    logic [31:0] host_post_addr, host_read_addr;
    logic [3:0]  q_empty, q_ovf;
    logic        post_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct { logic [3:0] a; logic [31:0] e; string tag; } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    msgq_ptr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rd_addr(sw_rd_addr), .sw_rdata(sw_rdata),
        .host_post(host_post), .host_read(host_read),
        .host_post_addr(host_post_addr), .host_read_addr(host_read_addr),
        .q_empty(q_empty), .q_ovf(q_ovf), .post_irq(post_irq)
    );

    function automatic logic [31:0] qs(input logic [31:0] b, input int sz, input int q);
        return (b & 32'hFFF0_0000) + 32'(q * sz * 16384);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard and compares the readback
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            chk(it.tag, sw_rdata, it.e);
        end
    end

    // driver: present a read address and queue its expected value
    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        sw_rd_addr = a;
        it.a = a; it.e = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic post1();
        @(negedge clk); host_post = 1'b1;
        @(negedge clk); host_post = 1'b0;
    endtask

    task automatic read1();
        @(negedge clk); host_read = 1'b1;
        @(negedge clk); host_read = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] b;
        b = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int r = 0; r < 10; r++) rd(4'(r), 32'h0, "R1 reg");
        @(negedge clk); #2;
        chk("R1 empty", 32'(q_empty), 32'hF);
        chk("R1 ovf", 32'(q_ovf), 32'h0);
        chk("R1 irq", 32'(post_irq), 32'h0);

        // R2 base masking
        wr(4'd1, b);
        rd(4'd1, 32'h1230_0000, "R2 base");

        // R11 disabled: host strobes ignored, software writes work
        post1(); read1();
        rd(4'd4, 32'h0, "R11 ip head idle");
        rd(4'd7, 32'h0, "R11 op tail idle");
        wr(4'd4, 32'h0000_0ABC);
        rd(4'd4, 32'h0000_0ABC, "R11 sw write");
        @(negedge clk); #2;
        chk("R9 ip nonempty", 32'(q_empty[1]), 32'h0);
        chk("R10 irq", 32'(post_irq), 32'h1);

        // R4 / R3 enable with size 2
        wr(4'd0, 32'h5);
        rd(4'd0, 32'h5, "R2 ctrl");
        for (int q = 0; q < 4; q++) begin
            rd(4'(2 + 2*q), qs(b, 2, q), "R3 head start");
            rd(4'(3 + 2*q), qs(b, 2, q), "R4 tail start");
        end
        @(negedge clk); #2;
        chk("R9 all empty", 32'(q_empty), 32'hF);
        chk("R10 irq low", 32'(post_irq), 32'h0);

        // R5 host post advance
        post1(); #2;
        chk("R5 post addr", host_post_addr, qs(b, 2, 1) + 4);
        chk("R10 irq after post", 32'(post_irq), 32'h1);
        rd(4'd4, qs(b, 2, 1) + 4, "R5 ip head");

        // R6 wrap
        wr(4'd4, qs(b, 2, 1) + 32'h7FFC);
        wr(4'd5, qs(b, 2, 1) + 32'h4000);
        post1(); #2;
        chk("R6 wrap", host_post_addr, qs(b, 2, 1));

        // R7 overflow refusal
        wr(4'd5, qs(b, 2, 1) + 4);
        post1(); #2;
        chk("R7 head held", host_post_addr, qs(b, 2, 1));
        chk("R7 ovf flag", 32'(q_ovf), 32'h2);
        chk("R7 still pending", 32'(post_irq), 32'h1);

        // R8 host read
        read1(); #2;
        chk("R8 empty read ignored", host_read_addr, qs(b, 2, 2));
        wr(4'd6, qs(b, 2, 2) + 8);
        read1(); #2;
        chk("R8 read advance", host_read_addr, qs(b, 2, 2) + 4);
        chk("R9 op nonempty", 32'(q_empty[2]), 32'h0);
        read1(); #2;
        chk("R8 second read", host_read_addr, qs(b, 2, 2) + 8);
        chk("R9 op empty", 32'(q_empty[2]), 32'h1);

        // R4 re-enable with size 1 clears overflow and re-places pointers
        wr(4'd0, 32'h3);
        rd(4'd4, qs(b, 1, 1), "R4 ip head size1");
        rd(4'd9, qs(b, 1, 3), "R3 of tail size1");
        @(negedge clk); #2;
        chk("R4 ovf cleared", 32'(q_ovf), 32'h0);

        // R11 disable again: posts ignored
        wr(4'd0, 32'h2);
        post1(); #2;
        chk("R11 post ignored", host_post_addr, qs(b, 1, 1));

        @(negedge clk); @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule